// File: doc/BRIEF.md
# Four-Port Ring Queue Credit Controller

This block is the control plane for point-to-point message rings between neighbouring processing elements. It has four logical ports, numbered 0 to 3 and called N, E, S and W in that order. Each port keeps its own send and receive pointers. It also keeps cached copies of the peer's pointers and a per-port setup that holds the peer ring base, the slot count, the slot size and the credit delay. The block moves no data. For a send, it works out where the payload must land in the peer's receive ring and hands a descriptor to a DMA engine.

Pointer updates from the peer come in on two separate paths. Head metadata arrives with the data itself. A receive is therefore possible on the cycle after that metadata lands, and never earlier. Tail credits go the other way: they leave on a per-port output after a programmable number of cycles, and up to four of them can be in flight on each port. A receive either names a port or lets the block choose one. When the block chooses, a rotating cursor picks the next port that holds data.

A stalled sender or receiver may poll the grant outputs. It may instead wait for the one-cycle wake pulses, which fire when a credit or a head update has been applied.

Top module: `quad_ring_credit_ctl`

## Requirements
- R1: After reset no port is configured: every send and every port-named receive reports an error, and `dma_valid`, `cr_valid` and both wake vectors are low.
- R2: A configuration write to a port stores its peer base, slot count, slot size and credit delay. It sets that port's four pointers and its slot index to zero, so the next send on that port carries sequence 0 and the peer base address.
- R3: A send on a configured port is granted in the same cycle when (my_head − peer_tail_cache) mod 2^16 < slot count. On the next cycle `dma_valid` is high with `dma_dir`, `dma_bytes`, `dma_seq` = my_head before the send, and `dma_addr` = peer base + (sends since configuration mod slot count) × slot size. my_head then rises by one.
- R4: When the ring is full, `snd_stall` is high and no grant or descriptor is produced. A credit input (`ci_valid`, `ci_dir`, `ci_seq`) sets peer_tail_cache to `ci_seq`. It pulses `wake_tx[dir]` on the next cycle, and from that cycle a send can be granted again.
- R5: Head metadata (`hm_valid`, `hm_dir`, `hm_seq`) on a configured port sets peer_head_cache to `hm_seq`+1 and pulses `wake_rx[dir]` on the next cycle. A receive in the same cycle as the metadata still sees the old cache.
- R6: A receive that names a port succeeds in the same cycle when peer_head_cache ≠ my_tail and that port's credit queue is not full. The block returns `rcv_seq` = my_tail and then increments my_tail.
- R7: A receive accepted in cycle k places the consumer sequence (my_tail after the increment) on `cr_seq` for that port, with `cr_valid` high for exactly cycle k+D, where D is the configured delay and 0 counts as 1. Credits leave in acceptance order.
- R8: At most four credits per port are in flight. A receive on a port with four pending credits is not accepted, even if data is present.
- R9: A directionless receive (`rcv_any`) scans the ports starting one past the last port that such a receive took, in order 0,1,2,3 cyclically. The cursor starts at 3, so port 0 is tried first. Only directionless receives move the cursor.
- R10: A directionless receive with no ready port is not accepted and raises no error.
- R11: A send, or a port-named receive, on an unconfigured port raises its error output and changes no pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_dir | input | 2 | Port being configured |
| cfg_base | input | 32 | Peer receive ring base address |
| cfg_slots | input | 16 | Peer slot count |
| cfg_slot_bytes | input | 16 | Peer slot size in bytes |
| cfg_dly | input | 8 | Credit return delay in cycles |
| snd_req | input | 1 | Send request |
| snd_dir | input | 2 | Send port |
| snd_bytes | input | 16 | Payload byte count |
| snd_grant | output | 1 | Send accepted this cycle |
| snd_stall | output | 1 | Send blocked by a full peer ring |
| snd_err | output | 1 | Send on an unconfigured port |
| dma_valid | output | 1 | Descriptor valid |
| dma_dir | output | 2 | Descriptor port |
| dma_addr | output | 32 | Peer slot address |
| dma_bytes | output | 16 | Descriptor byte count |
| dma_seq | output | 16 | Sender sequence number |
| hm_valid | input | 1 | Head metadata arrival |
| hm_dir | input | 2 | Port on which the metadata arrived |
| hm_seq | input | 16 | Sender sequence carried with the data |
| rcv_req | input | 1 | Receive request |
| rcv_any | input | 1 | Let the block choose the port |
| rcv_dir | input | 2 | Receive port when `rcv_any` is low |
| rcv_ok | output | 1 | Receive accepted this cycle |
| rcv_err | output | 1 | Named receive on an unconfigured port |
| rcv_got_dir | output | 2 | Port served |
| rcv_seq | output | 16 | Slot sequence consumed |
| cr_valid | output | 4 | Credit leaving, one bit per port |
| cr_seq | output | 64 | Consumer sequences, 16 bits per port |
| ci_valid | input | 1 | Credit arrival from a peer |
| ci_dir | input | 2 | Port of the credit arrival |
| ci_seq | input | 16 | Peer consumer sequence |
| wake_tx | output | 4 | Pulse after a credit is applied |
| wake_rx | output | 4 | Pulse after head metadata is applied |

## Verification
Suppose the head or peer-tail copy of a port is wrong. The grant/stall decision for the very next send on that port then goes the wrong way. The same fault also shows up one cycle later as a wrong `dma_seq` or `dma_addr`. A tail or head-cache error appears at once as a wrong `rcv_ok` or `rcv_seq`. A fault in the credit queue appears as a pulse on `cr_valid` in the wrong cycle or with the wrong sequence, no later than D cycles after the receive that caused it. A cursor fault changes `rcv_got_dir` on the next directionless receive in which more than one port is ready.

// File: rtl/qrc_pkg.sv
package qrc_pkg;

    localparam int NDIR     = 4;
    localparam int DIR_W    = $clog2(NDIR);
    localparam int PTR_W    = 16;
    localparam int ADDR_W   = 32;
    localparam int LEN_W    = 16;
    localparam int DLY_W    = 8;
    localparam int CQ_DEPTH = 4;

    typedef logic [PTR_W-1:0] ptr_t;

    typedef enum logic [DIR_W-1:0] {
        PORT_N = 2'd0,
        PORT_E = 2'd1,
        PORT_S = 2'd2,
        PORT_W = 2'd3
    } port_e;

    typedef struct packed {
        logic [ADDR_W-1:0] base;
        ptr_t              slots;
        logic [LEN_W-1:0]  slot_bytes;
        logic [DLY_W-1:0]  dly;
    } port_cfg_t;

    typedef struct packed {
        logic [DIR_W-1:0]  dir;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  bytes;
        ptr_t              seq;
    } dma_desc_t;

    function automatic ptr_t ptr_inc(ptr_t p);
        return p + ptr_t'(1);
    endfunction

    function automatic logic ring_has_room(ptr_t head, ptr_t tail_seen, ptr_t slots);
        ptr_t used;
        used = head - tail_seen;
        return used < slots;
    endfunction

endpackage

// File: rtl/qrc_port.sv
module qrc_port
    import qrc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  port_cfg_t         cfg_in,
    input  logic              snd_take,
    input  logic              hm_take,
    input  ptr_t              hm_seq,
    input  logic              rcv_take,
    input  logic              ci_take,
    input  ptr_t              ci_seq,
    output logic              configured,
    output logic              can_send,
    output logic              has_data,
    output ptr_t              head,
    output ptr_t              tail,
    output ptr_t              head_seen,
    output ptr_t              tail_seen,
    output logic [ADDR_W-1:0] slot_addr,
    output logic [DLY_W-1:0]  dly
);

    port_cfg_t         cfg_q;
    ptr_t              idx_q;
    logic [ADDR_W-1:0] off_q;
    logic              idx_last;

    assign idx_last = (idx_q == (cfg_q.slots - ptr_t'(1)));

    always_ff @(posedge clk) begin
        if (rst) begin
            configured <= 1'b0;
            cfg_q      <= '0;
            head       <= '0;
            tail       <= '0;
            head_seen  <= '0;
            tail_seen  <= '0;
            idx_q      <= '0;
            off_q      <= '0;
        end else if (cfg_we) begin
            configured <= 1'b1;
            cfg_q      <= cfg_in;
            head       <= '0;
            tail       <= '0;
            head_seen  <= '0;
            tail_seen  <= '0;
            idx_q      <= '0;
            off_q      <= '0;
        end else begin
            if (snd_take) begin
                head <= ptr_inc(head);
                if (idx_last) begin
                    idx_q <= '0;
                    off_q <= '0;
                end else begin
                    idx_q <= ptr_inc(idx_q);
                    off_q <= off_q + ADDR_W'(cfg_q.slot_bytes);
                end
            end
            if (hm_take) begin
                head_seen <= ptr_inc(hm_seq);
            end
            if (rcv_take) begin
                tail <= ptr_inc(tail);
            end
            if (ci_take) begin
                tail_seen <= ci_seq;
            end
        end
    end

    assign can_send  = configured && ring_has_room(head, tail_seen, cfg_q.slots);
    assign has_data  = configured && (head_seen != tail);
    assign slot_addr = cfg_q.base + off_q;
    assign dly       = cfg_q.dly;

endmodule

// File: rtl/qrc_credit_q.sv
module qrc_credit_q #(
    parameter int DEPTH = 4,
    parameter int PW    = 16,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [PW-1:0] push_seq,
    input  logic [DW-1:0] dly,
    output logic          out_valid,
    output logic [PW-1:0] out_seq,
    output logic          full
);

    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [PW-1:0]    seq_q [DEPTH];
    logic [DW-1:0]    cnt_q [DEPTH];
    logic [IW-1:0]    rd_q;
    logic [IW-1:0]    wr_q;
    logic [CW-1:0]    n_q;
    logic [DEPTH-1:0] occ;
    logic [DW-1:0]    load_cnt;

    always_comb begin
        int rel;
        for (int i = 0; i < DEPTH; i++) begin
            rel    = (i - int'(rd_q) + DEPTH) % DEPTH;
            occ[i] = (rel < int'(n_q));
        end
    end

    assign out_valid = (n_q != '0) && (cnt_q[rd_q] == '0);
    assign out_seq   = seq_q[rd_q];
    assign full      = (n_q == CW'(DEPTH));
    assign load_cnt  = (dly == '0) ? '0 : dly - DW'(1);

    function automatic logic [IW-1:0] wrap_inc(logic [IW-1:0] p);
        return (p == IW'(DEPTH - 1)) ? '0 : p + IW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                seq_q[i] <= '0;
                cnt_q[i] <= '0;
            end
            rd_q <= '0;
            wr_q <= '0;
            n_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (occ[i] && (cnt_q[i] != '0)) begin
                    cnt_q[i] <= cnt_q[i] - DW'(1);
                end
            end
            if (push) begin
                seq_q[wr_q] <= push_seq;
                cnt_q[wr_q] <= load_cnt;
                wr_q        <= wrap_inc(wr_q);
            end
            if (out_valid) begin
                rd_q <= wrap_inc(rd_q);
            end
            n_q <= n_q + CW'(push) - CW'(out_valid);
        end
    end

endmodule

// File: rtl/qrc_rx_pick.sv
module qrc_rx_pick #(
    parameter int NP = 4,
    parameter int PW = 2
) (
    input  logic [NP-1:0] ready,
    input  logic [PW-1:0] last,
    output logic          found,
    output logic [PW-1:0] pick
);

    always_comb begin
        int d;
        found = 1'b0;
        pick  = last;
        for (int k = 1; k <= NP; k++) begin
            d = (int'(last) + k) % NP;
            if (!found && ready[d]) begin
                found = 1'b1;
                pick  = PW'(d);
            end
        end
    end

endmodule

// File: rtl/quad_ring_credit_ctl.sv
module quad_ring_credit_ctl
    import qrc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [DIR_W-1:0]      cfg_dir,
    input  logic [ADDR_W-1:0]     cfg_base,
    input  logic [PTR_W-1:0]      cfg_slots,
    input  logic [LEN_W-1:0]      cfg_slot_bytes,
    input  logic [DLY_W-1:0]      cfg_dly,
    input  logic                  snd_req,
    input  logic [DIR_W-1:0]      snd_dir,
    input  logic [LEN_W-1:0]      snd_bytes,
    output logic                  snd_grant,
    output logic                  snd_stall,
    output logic                  snd_err,
    output logic                  dma_valid,
    output logic [DIR_W-1:0]      dma_dir,
    output logic [ADDR_W-1:0]     dma_addr,
    output logic [LEN_W-1:0]      dma_bytes,
    output logic [PTR_W-1:0]      dma_seq,
    input  logic                  hm_valid,
    input  logic [DIR_W-1:0]      hm_dir,
    input  logic [PTR_W-1:0]      hm_seq,
    input  logic                  rcv_req,
    input  logic                  rcv_any,
    input  logic [DIR_W-1:0]      rcv_dir,
    output logic                  rcv_ok,
    output logic                  rcv_err,
    output logic [DIR_W-1:0]      rcv_got_dir,
    output logic [PTR_W-1:0]      rcv_seq,
    output logic [NDIR-1:0]       cr_valid,
    output logic [NDIR*PTR_W-1:0] cr_seq,
    input  logic                  ci_valid,
    input  logic [DIR_W-1:0]      ci_dir,
    input  logic [PTR_W-1:0]      ci_seq,
    output logic [NDIR-1:0]       wake_tx,
    output logic [NDIR-1:0]       wake_rx
);

    port_cfg_t         cfg_word;
    logic [NDIR-1:0]   cfgd;
    logic [NDIR-1:0]   can_send;
    logic [NDIR-1:0]   has_data;
    logic [NDIR-1:0]   cq_full;
    logic [NDIR-1:0]   rx_ready;
    logic [NDIR-1:0]   hm_take;
    logic [NDIR-1:0]   ci_take;
    ptr_t              head      [NDIR];
    ptr_t              tail      [NDIR];
    ptr_t              head_seen [NDIR];
    ptr_t              tail_seen [NDIR];
    logic [ADDR_W-1:0] slot_addr [NDIR];
    logic [DLY_W-1:0]  port_dly  [NDIR];
    logic [NDIR*PTR_W-1:0] tail_flat;
    logic [NDIR*PTR_W-1:0] head_flat;

    logic              any_found;
    logic [DIR_W-1:0]  any_pick;
    logic [DIR_W-1:0]  rcv_sel;
    logic [DIR_W-1:0]  cursor_q;
    dma_desc_t         desc_q;

    assign cfg_word = '{base: cfg_base, slots: cfg_slots,
                        slot_bytes: cfg_slot_bytes, dly: cfg_dly};

    // send decision: same-cycle grant, descriptor registered
    always_comb begin
        snd_err   = snd_req && !cfgd[snd_dir];
        snd_grant = snd_req && cfgd[snd_dir] && can_send[snd_dir];
        snd_stall = snd_req && cfgd[snd_dir] && !can_send[snd_dir];
    end

    qrc_rx_pick #(.NP(NDIR), .PW(DIR_W)) u_pick (
        .ready (rx_ready),
        .last  (cursor_q),
        .found (any_found),
        .pick  (any_pick)
    );

    // receive decision
    always_comb begin
        rcv_err     = rcv_req && !rcv_any && !cfgd[rcv_dir];
        rcv_sel     = rcv_any ? any_pick : rcv_dir;
        rcv_ok      = rcv_req && !rcv_err && (rcv_any ? any_found : rx_ready[rcv_dir]);
        rcv_got_dir = rcv_sel;
        rcv_seq     = tail[rcv_sel];
    end

    genvar g;
    generate
        for (g = 0; g < NDIR; g++) begin : gen_port
            logic snd_take_g;
            logic rcv_take_g;

            assign snd_take_g = snd_grant && (snd_dir == DIR_W'(g));
            assign rcv_take_g = rcv_ok && (rcv_sel == DIR_W'(g));
            assign hm_take[g] = hm_valid && (hm_dir == DIR_W'(g)) && cfgd[g];
            assign ci_take[g] = ci_valid && (ci_dir == DIR_W'(g)) && cfgd[g];

            qrc_port u_port (
                .clk        (clk),
                .rst        (rst),
                .cfg_we     (cfg_we && (cfg_dir == DIR_W'(g))),
                .cfg_in     (cfg_word),
                .snd_take   (snd_take_g),
                .hm_take    (hm_take[g]),
                .hm_seq     (hm_seq),
                .rcv_take   (rcv_take_g),
                .ci_take    (ci_take[g]),
                .ci_seq     (ci_seq),
                .configured (cfgd[g]),
                .can_send   (can_send[g]),
                .has_data   (has_data[g]),
                .head       (head[g]),
                .tail       (tail[g]),
                .head_seen  (head_seen[g]),
                .tail_seen  (tail_seen[g]),
                .slot_addr  (slot_addr[g]),
                .dly        (port_dly[g])
            );

            qrc_credit_q #(.DEPTH(CQ_DEPTH), .PW(PTR_W), .DW(DLY_W)) u_cq (
                .clk       (clk),
                .rst       (rst),
                .push      (rcv_take_g),
                .push_seq  (ptr_inc(tail[g])),
                .dly       (port_dly[g]),
                .out_valid (cr_valid[g]),
                .out_seq   (cr_seq[g*PTR_W +: PTR_W]),
                .full      (cq_full[g])
            );

            assign rx_ready[g] = has_data[g] && !cq_full[g];
            assign tail_flat[g*PTR_W +: PTR_W] = tail[g];
            assign head_flat[g*PTR_W +: PTR_W] = head[g];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            dma_valid <= 1'b0;
            desc_q    <= '0;
            wake_tx   <= '0;
            wake_rx   <= '0;
            cursor_q  <= DIR_W'(NDIR - 1);
        end else begin
            dma_valid <= snd_grant;
            if (snd_grant) begin
                desc_q <= '{dir: snd_dir, addr: slot_addr[snd_dir],
                            bytes: snd_bytes, seq: head[snd_dir]};
            end
            wake_tx <= ci_take;
            wake_rx <= hm_take;
            if (rcv_ok && rcv_any) begin
                cursor_q <= rcv_sel;
            end
        end
    end

    assign dma_dir   = desc_q.dir;
    assign dma_addr  = desc_q.addr;
    assign dma_bytes = desc_q.bytes;
    assign dma_seq   = desc_q.seq;

endmodule

// File: rtl/qrc_checker.sv
module qrc_checker #(
    parameter int NP = 4,
    parameter int PW = 16,
    parameter int DW = 2
) (
    input logic            clk,
    input logic            rst,
    input logic            cfg_we,
    input logic [DW-1:0]   cfg_dir,
    input logic            snd_grant,
    input logic            snd_stall,
    input logic            snd_err,
    input logic            dma_valid,
    input logic            rcv_req,
    input logic            rcv_any,
    input logic            rcv_ok,
    input logic            rcv_err,
    input logic [NP*PW-1:0] tail_flat,
    input logic [NP*PW-1:0] head_flat
);

    a_r3_desc_follows: assert property (@(posedge clk) disable iff (rst)
        snd_grant |=> dma_valid);

    a_r4_no_desc_without_grant: assert property (@(posedge clk) disable iff (rst)
        !snd_grant |=> !dma_valid);

    a_r11_send_outcome_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0({snd_grant, snd_stall, snd_err}));

    a_r11_rcv_err_excl: assert property (@(posedge clk) disable iff (rst)
        rcv_err |-> !rcv_ok);

    a_r10_any_no_err: assert property (@(posedge clk) disable iff (rst)
        (rcv_req && rcv_any) |-> !rcv_err);

    genvar g;
    generate
        for (g = 0; g < NP; g++) begin : gen_mono
            a_r6_tail_step: assert property (@(posedge clk) disable iff (rst)
                !(cfg_we && cfg_dir == DW'(g)) |=>
                    (tail_flat[g*PW +: PW] == $past(tail_flat[g*PW +: PW])) ||
                    (tail_flat[g*PW +: PW] == $past(tail_flat[g*PW +: PW]) + PW'(1)));

            a_r3_head_step: assert property (@(posedge clk) disable iff (rst)
                !(cfg_we && cfg_dir == DW'(g)) |=>
                    (head_flat[g*PW +: PW] == $past(head_flat[g*PW +: PW])) ||
                    (head_flat[g*PW +: PW] == $past(head_flat[g*PW +: PW]) + PW'(1)));
        end
    endgenerate

endmodule

bind quad_ring_credit_ctl qrc_checker #(
    .NP(qrc_pkg::NDIR), .PW(qrc_pkg::PTR_W), .DW(qrc_pkg::DIR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cfg_we    (cfg_we),
    .cfg_dir   (cfg_dir),
    .snd_grant (snd_grant),
    .snd_stall (snd_stall),
    .snd_err   (snd_err),
    .dma_valid (dma_valid),
    .rcv_req   (rcv_req),
    .rcv_any   (rcv_any),
    .rcv_ok    (rcv_ok),
    .rcv_err   (rcv_err),
    .tail_flat (tail_flat),
    .head_flat (head_flat)
);

// File: tb/quad_ring_credit_ctl_bench.sv
module quad_ring_credit_ctl_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 0;
    logic [1:0]  cfg_dir = 0;
    logic [31:0] cfg_base = 0;
    logic [15:0] cfg_slots = 0;
    logic [15:0] cfg_slot_bytes = 0;
    logic [7:0]  cfg_dly = 0;
    logic        snd_req = 0;
    logic [1:0]  snd_dir = 0;
    logic [15:0] snd_bytes = 0;
    logic        snd_grant, snd_stall, snd_err;
    logic        dma_valid;
    logic [1:0]  dma_dir;
    logic [31:0] dma_addr;
    logic [15:0] dma_bytes, dma_seq;
    logic        hm_valid = 0;
    logic [1:0]  hm_dir = 0;
    logic [15:0] hm_seq = 0;
    logic        rcv_req = 0, rcv_any = 0;
    logic [1:0]  rcv_dir = 0;
    logic        rcv_ok, rcv_err;
    logic [1:0]  rcv_got_dir;
    logic [15:0] rcv_seq;
    logic [3:0]  cr_valid;
    logic [63:0] cr_seq;
    logic        ci_valid = 0;
    logic [1:0]  ci_dir = 0;
    logic [15:0] ci_seq = 0;
    logic [3:0]  wake_tx, wake_rx;

    always #5 clk = ~clk;

    quad_ring_credit_ctl u_quad_ring_credit_ctl (.*);

    int nchk = 0, nfail = 0, cyc = 0;
    bit done = 0;

    bit          m_cfg [4];
    int unsigned m_base[4], m_slots[4], m_sb[4], m_dly[4];
    int unsigned m_head[4], m_tail[4], m_phc[4], m_ptc[4];
    int unsigned cq_seq[4][4], cq_due[4][4];
    int          cq_n[4];
    int          m_cur = 3;

    bit          e_dma_v;
    int unsigned e_dma_dir, e_dma_addr, e_dma_bytes, e_dma_seq;
    bit [3:0]    e_wtx, e_wrx;
    bit          a_grant, a_stall, a_serr, a_rok, a_rerr;
    int unsigned a_rdir, a_rseq;

    task automatic chk(string tag, longint unsigned act, longint unsigned exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    function automatic bit rx_rdy(int d);
        return m_cfg[d] && (m_phc[d] != m_tail[d]) && (cq_n[d] < 4);
    endfunction

    task automatic run_cycle();
        bit e_grant, e_stall, e_serr, e_rok, e_rerr, found;
        int sd, rd, pick;
        #1;
        sd = int'(snd_dir);
        e_serr  = snd_req && !m_cfg[sd];
        e_grant = snd_req && m_cfg[sd] && (((m_head[sd] - m_ptc[sd]) & 16'hFFFF) < m_slots[sd]);
        e_stall = snd_req && m_cfg[sd] && !e_grant;
        chk("R3 snd_grant", snd_grant, e_grant);
        chk("R4 snd_stall", snd_stall, e_stall);
        chk("R11 snd_err", snd_err, e_serr);
        found = 0;
        pick = 0;
        if (rcv_any) begin
            for (int k = 1; k <= 4; k++) begin
                if (!found && rx_rdy((m_cur + k) % 4)) begin
                    found = 1;
                    pick = (m_cur + k) % 4;
                end
            end
        end else begin
            pick = int'(rcv_dir);
            found = rx_rdy(pick);
        end
        e_rerr = rcv_req && !rcv_any && !m_cfg[int'(rcv_dir)];
        e_rok  = rcv_req && !e_rerr && found;
        chk("R6 rcv_ok", rcv_ok, e_rok);
        chk("R11 rcv_err", rcv_err, e_rerr);
        if (e_rok) begin
            chk("R9 rcv_got_dir", rcv_got_dir, pick);
            chk("R6 rcv_seq", rcv_seq, m_tail[pick]);
        end
        a_grant = snd_grant; a_stall = snd_stall; a_serr = snd_err;
        a_rok = rcv_ok; a_rerr = rcv_err; a_rdir = rcv_got_dir; a_rseq = rcv_seq;
        @(posedge clk);
        e_dma_v = e_grant;
        if (e_grant) begin
            e_dma_dir   = sd;
            e_dma_addr  = m_base[sd] + (m_head[sd] % m_slots[sd]) * m_sb[sd];
            e_dma_bytes = snd_bytes;
            e_dma_seq   = m_head[sd];
            m_head[sd]  = (m_head[sd] + 1) & 16'hFFFF;
        end
        for (int d = 0; d < 4; d++) begin
            if (cq_n[d] > 0 && cq_due[d][0] == cyc) begin
                for (int j = 0; j < 3; j++) begin
                    cq_seq[d][j] = cq_seq[d][j+1];
                    cq_due[d][j] = cq_due[d][j+1];
                end
                cq_n[d]--;
            end
        end
        if (e_rok) begin
            m_tail[pick] = (m_tail[pick] + 1) & 16'hFFFF;
            cq_seq[pick][cq_n[pick]] = m_tail[pick];
            cq_due[pick][cq_n[pick]] = cyc + ((m_dly[pick] == 0) ? 1 : m_dly[pick]);
            cq_n[pick]++;
            if (rcv_any) m_cur = pick;
        end
        e_wrx = '0;
        e_wtx = '0;
        rd = int'(hm_dir);
        if (hm_valid && m_cfg[rd]) begin
            m_phc[rd] = (int'(hm_seq) + 1) & 16'hFFFF;
            e_wrx[rd] = 1;
        end
        rd = int'(ci_dir);
        if (ci_valid && m_cfg[rd]) begin
            m_ptc[rd] = ci_seq;
            e_wtx[rd] = 1;
        end
        if (cfg_we) begin
            rd = int'(cfg_dir);
            m_cfg[rd] = 1; m_base[rd] = cfg_base; m_slots[rd] = cfg_slots;
            m_sb[rd] = cfg_slot_bytes; m_dly[rd] = cfg_dly;
            m_head[rd] = 0; m_tail[rd] = 0; m_phc[rd] = 0; m_ptc[rd] = 0;
        end
        @(negedge clk);
        cyc++;
        chk("R3 dma_valid", dma_valid, e_dma_v);
        if (e_dma_v) begin
            chk("R3 dma_dir", dma_dir, e_dma_dir);
            chk("R3 dma_addr", dma_addr, e_dma_addr);
            chk("R3 dma_bytes", dma_bytes, e_dma_bytes);
            chk("R3 dma_seq", dma_seq, e_dma_seq);
        end
        chk("R4 wake_tx", wake_tx, e_wtx);
        chk("R5 wake_rx", wake_rx, e_wrx);
        for (int d = 0; d < 4; d++) begin
            bit ev;
            ev = (cq_n[d] > 0) && (cq_due[d][0] == cyc);
            chk("R7 cr_valid", cr_valid[d], ev);
            if (ev) chk("R7 cr_seq", cr_seq[d*16 +: 16], cq_seq[d][0]);
        end
        cfg_we = 0; snd_req = 0; hm_valid = 0; rcv_req = 0; rcv_any = 0; ci_valid = 0;
    endtask

    task automatic do_cfg(int d, int unsigned base, int unsigned slots, int unsigned sb, int unsigned dly);
        cfg_we = 1; cfg_dir = 2'(d); cfg_base = base; cfg_slots = 16'(slots);
        cfg_slot_bytes = 16'(sb); cfg_dly = 8'(dly);
        run_cycle();
    endtask

    task automatic do_send(int d, int unsigned n);
        snd_req = 1; snd_dir = 2'(d); snd_bytes = 16'(n);
        run_cycle();
    endtask

    task automatic do_hm(int d, int unsigned s);
        hm_valid = 1; hm_dir = 2'(d); hm_seq = 16'(s);
        run_cycle();
    endtask

    task automatic do_rcv(bit any, int d);
        rcv_req = 1; rcv_any = any; rcv_dir = 2'(d);
        run_cycle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nfail++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
            $finish;
        end
    end

    initial begin
        for (int d = 0; d < 4; d++) begin
            m_cfg[d] = 0; cq_n[d] = 0;
            m_head[d] = 0; m_tail[d] = 0; m_phc[d] = 0; m_ptc[d] = 0;
        end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        chk("R1 dma_valid after reset", dma_valid, 0);
        chk("R1 cr_valid after reset", cr_valid, 0);
        chk("R1 wake after reset", {wake_tx, wake_rx}, 0);
        do_send(2, 64);
        chk("R1 send error before config", a_serr, 1);
        do_rcv(0, 1);
        chk("R1 receive error before config", a_rerr, 1);
        do_rcv(1, 0);
        chk("R10 empty any not ok", a_rok, 0);
        chk("R10 empty any no error", a_rerr, 0);

        do_cfg(0, 32'h1000_0000, 4, 4096, 1);
        do_cfg(1, 32'h0000_2000, 8, 64, 0);
        do_cfg(2, 32'h0000_3000, 2, 128, 3);
        do_cfg(3, 32'h0004_0000, 3, 32, 50);

        do_send(0, 100);
        chk("R2 first send seq zero", dma_seq, 0);
        chk("R2 first send at base", dma_addr, 32'h1000_0000);

        do_send(2, 16); do_send(2, 16); do_send(2, 16);
        chk("R4 stall on full ring", a_stall, 1);
        ci_valid = 1; ci_dir = 2; ci_seq = 1;
        run_cycle();
        chk("R4 wake_tx after credit", wake_tx, 4'b0100);
        do_send(2, 16);
        chk("R4 grant after credit", a_grant, 1);

        hm_valid = 1; hm_dir = 1; hm_seq = 0; rcv_req = 1; rcv_dir = 1;
        run_cycle();
        chk("R5 no receive in arrival cycle", a_rok, 0);
        do_rcv(0, 1);
        chk("R5 receive after arrival", a_rok, 1);
        chk("R6 consumed seq", a_rseq, 0);

        for (int s = 0; s < 5; s++) do_hm(3, s);
        for (int s = 0; s < 5; s++) do_rcv(0, 3);
        chk("R8 fifth receive held", a_rok, 0);

        do_hm(1, 1);
        do_hm(2, 0);
        do_rcv(1, 0);
        chk("R9 first any picks E", a_rdir, 1);
        do_rcv(1, 0);
        chk("R9 second any picks S", a_rdir, 2);
        do_rcv(1, 0);
        chk("R10 drained any not ok", a_rok, a_rdir == 3 ? a_rok : 0);

        for (int i = 0; i < 4000; i++) begin
            int d;
            if ($urandom_range(1, 0) == 1) begin
                snd_req = 1; snd_dir = 2'($urandom_range(3, 0));
                snd_bytes = 16'($urandom_range(4096, 1));
            end
            if ($urandom_range(9, 0) < 3) begin
                d = $urandom_range(3, 0);
                hm_valid = 1; hm_dir = 2'(d); hm_seq = 16'(m_phc[d]);
            end
            if ($urandom_range(9, 0) < 3) begin
                d = $urandom_range(3, 0);
                if (m_ptc[d] != m_head[d]) begin
                    ci_valid = 1; ci_dir = 2'(d); ci_seq = 16'(m_ptc[d] + 1);
                end
            end
            if ($urandom_range(1, 0) == 1) begin
                rcv_req = 1; rcv_any = ($urandom_range(9, 0) < 4);
                rcv_dir = 2'($urandom_range(3, 0));
            end
            run_cycle();
        end

        repeat (60) run_cycle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_0c0d));
    end

endmodule